// File: doc/BRIEF.md
# Low-Power Mode Sequencing Controller

This block moves a small processor subsystem among four operating modes (active, idle, standby and shutdown) and a transient wake state. Software chooses a mode by sending a request code while the system is active. The controller then drives the clock enables for the CPU, memory and peripherals. It also drives the retention enable, the pad-hold (I/O latch) enable and the brown-out-detector enable. Each low-power mode has its own set of wake sources and its own wake latency. That latency is counted out in clock cycles before the CPU clock comes back.

A wake from shutdown through a pin level change does not resume the previous state. It is treated as a reset: the controller pulses a clear for non-retained state and records a distinct cause bit in a reset-cause register. Power-on reset and the external reset pin also record their own bits. Software clears the cause bits by writing ones.

States: `ST_ACTIVE`, `ST_IDLE`, `ST_STANDBY`, `ST_SHUTDOWN`, `ST_WAKE`. Transitions:
- **request-idle**, **request-standby** and **request-shutdown** leave `ST_ACTIVE`.
- **idle-wake** and **standby-wake** go to `ST_WAKE` as a resume.
- **shutdown-wake** and **reset-pin** go to `ST_WAKE` as a reset.
- **wake-done** goes from `ST_WAKE` to `ST_ACTIVE`.
- **power-on** forces `ST_ACTIVE`.

Top module: `pwr_mode_seq`

## Requirements
- R1: A request is taken only in active mode, and it is applied one cycle after it is sampled. Code 1 selects idle, code 2 selects standby and code 3 selects shutdown. Code 0 and codes 4 to 7 leave the mode unchanged. A request made in any other state, including during a wake countdown, has no effect.
- R2: The CPU, memory and peripheral clock enables are all 1 in active. In idle only the peripheral enable is 1. In standby, shutdown and wake all three are 0. `state_o` encodes the state as active=0, idle=1, standby=2, shutdown=3 and wake=4.
- R3: In idle, only the interrupt line wakes the controller (parameter `IDLE_MASK`). An interrupt moves the state to wake. Active follows `LAT_IDLE` cycles after that move.
- R4: In standby, an RTC event, a co-processor event or any pin change wakes the controller (parameter `STBY_MASK`). The interrupt line is ignored. Active follows `LAT_STBY` cycles after the move to wake.
- R5: In shutdown, the interrupt, RTC and co-processor events are ignored, and so is a change on any pin whose `sd_pin_en_i` bit is 0. A change on an enabled pin has three effects: the state moves to wake, cause bit 2 is set, and `state_clr_o` pulses for one cycle. Active follows `LAT_SD` cycles later.
- R6: The reset pin forces the state to wake from every state, shutdown included. It also sets cause bit 1 and pulses `state_clr_o`. Active follows `LAT_SD` cycles after the pin is released.
- R7: Power-on reset puts the controller in active mode with the reset-cause register at 3'b001. Bit 0 means power-on, bit 1 means reset pin and bit 2 means shutdown pin wake.
- R8: The I/O latch enable is 1 in standby and shutdown, and 0 in every other state.
- R9: The retention enable is 1 only in standby.
- R10: The brown-out enable is 1 in active, idle and wake, and 0 in shutdown. In standby it is 1 for the first `BOD_ON` cycles of every `BOD_PERIOD`-cycle window, counted from standby entry.
- R11: Writing a 1 to a bit of `cause_clr_i` clears that cause bit on the next cycle. When a cause is set in the same cycle, setting wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_i | input | 1 | Power-on reset, active high, asynchronous |
| rstpin_i | input | 1 | External reset pin, active high |
| req_valid_i | input | 1 | Mode request strobe |
| req_mode_i | input | 3 | Requested mode code |
| irq_i | input | 1 | Interrupt line |
| rtc_evt_i | input | 1 | RTC event |
| cop_evt_i | input | 1 | Co-processor event |
| pin_chg_i | input | NPIN | Per-pin level-change flags |
| sd_pin_en_i | input | NPIN | Pins allowed to wake from shutdown |
| cause_clr_i | input | 3 | Write-one-to-clear for the cause bits |
| state_o | output | 3 | Current state code |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| mem_clk_en_o | output | 1 | Memory clock enable |
| per_clk_en_o | output | 1 | Peripheral clock enable |
| ret_en_o | output | 1 | Retention enable for the kept subset |
| io_latch_o | output | 1 | Pad-hold enable |
| bod_en_o | output | 1 | Brown-out detector enable |
| state_clr_o | output | 1 | Clear pulse for non-retained state |
| rst_cause_o | output | 3 | Reset-cause register |

## Verification
A stimulus applied before a clock edge shows up as a new state, new enables, a new cause value or a clear pulse in the cycle right after that edge. The active state returns exactly 14, 174 or 1015 cycles after the wake state first appears. The brown-out pulse train repeats every 16 cycles from standby entry. The bench pushes each expected value with a due cycle counted from the cycle in which the stimulus was driven. A monitor compares values at the falling edge of exactly that cycle, so every latency is checked to the cycle, including the last cycle still in wake.

// File: rtl/pms_pkg.sv
package pms_pkg;
    typedef enum logic [2:0] {
        ST_ACTIVE   = 3'd0,
        ST_IDLE     = 3'd1,
        ST_STANDBY  = 3'd2,
        ST_SHUTDOWN = 3'd3,
        ST_WAKE     = 3'd4
    } pms_state_e;

    localparam int SRC_IRQ = 0;
    localparam int SRC_RTC = 1;
    localparam int SRC_COP = 2;
    localparam int SRC_PIN = 3;
    localparam int NSRC    = 4;

    localparam int CAUSE_POR = 0;
    localparam int CAUSE_PIN = 1;
    localparam int CAUSE_SDW = 2;
    localparam int NCAUSE    = 3;
endpackage

// File: rtl/pms_wake_filter.sv
module pms_wake_filter
    import pms_pkg::*;
#(
    parameter int              NPIN      = 4,
    parameter logic [NSRC-1:0] IDLE_MASK = 4'b0001,
    parameter logic [NSRC-1:0] STBY_MASK = 4'b1110
) (
    input  pms_state_e      state_i,
    input  logic            irq_i,
    input  logic            rtc_i,
    input  logic            cop_i,
    input  logic [NPIN-1:0] pin_chg_i,
    input  logic [NPIN-1:0] sd_pin_en_i,
    output logic            resume_o,
    output logic            sd_wake_o
);
    logic [NSRC-1:0] src;
    logic [NPIN-1:0] sd_hit;

    genvar gi;
    generate
        for (gi = 0; gi < NPIN; gi++) begin : g_pin
            assign sd_hit[gi] = pin_chg_i[gi] & sd_pin_en_i[gi];
        end
    endgenerate

    always_comb begin
        src          = '0;
        src[SRC_IRQ] = irq_i;
        src[SRC_RTC] = rtc_i;
        src[SRC_COP] = cop_i;
        src[SRC_PIN] = |pin_chg_i;
    end

    assign resume_o  = ((state_i == ST_IDLE)    && |(src & IDLE_MASK)) ||
                       ((state_i == ST_STANDBY) && |(src & STBY_MASK));
    assign sd_wake_o = (state_i == ST_SHUTDOWN) && |sd_hit;
endmodule

// File: rtl/pms_wake_timer.sv
module pms_wake_timer #(
    parameter int MAXV = 1015,
    localparam int W   = $clog2(MAXV + 1)
) (
    input  logic         clk,
    input  logic         por_i,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    output logic         expire_o
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or posedge por_i) begin
        if (por_i)              cnt_q <= '0;
        else if (load_i)        cnt_q <= load_val_i;
        else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end

    assign expire_o = (cnt_q == W'(1));

    assert_timer_step_R3: assert property (@(posedge clk) disable iff (por_i)
        (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/pms_bod_pulser.sv
module pms_bod_pulser #(
    parameter int PERIOD = 16,
    parameter int ON_CYC = 2,
    localparam int CW    = (PERIOD > 1) ? $clog2(PERIOD) : 1
) (
    input  logic clk,
    input  logic por_i,
    input  logic en_i,
    output logic pulse_o
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or posedge por_i) begin
        if (por_i)                        cnt_q <= '0;
        else if (!en_i)                   cnt_q <= '0;
        else if (cnt_q == CW'(PERIOD - 1)) cnt_q <= '0;
        else                              cnt_q <= cnt_q + 1'b1;
    end

    assign pulse_o = en_i && (cnt_q < CW'(ON_CYC));

    assert_bod_restart_R10: assert property (@(posedge clk) disable iff (por_i)
        (!en_i) |=> (cnt_q == '0));
    assert_bod_wrap_R10: assert property (@(posedge clk) disable iff (por_i)
        (en_i && $past(en_i) && cnt_q == '0) |-> ($past(cnt_q) == CW'(PERIOD - 1)));
endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
    import pms_pkg::*;
#(
    parameter int              NPIN       = 4,
    parameter int              LAT_IDLE   = 14,
    parameter int              LAT_STBY   = 174,
    parameter int              LAT_SD     = 1015,
    parameter int              BOD_PERIOD = 16,
    parameter int              BOD_ON     = 2,
    parameter logic [NSRC-1:0] IDLE_MASK  = 4'b0001,
    parameter logic [NSRC-1:0] STBY_MASK  = 4'b1110
) (
    input  logic            clk,
    input  logic            por_i,
    input  logic            rstpin_i,
    input  logic            req_valid_i,
    input  logic [2:0]      req_mode_i,
    input  logic            irq_i,
    input  logic            rtc_evt_i,
    input  logic            cop_evt_i,
    input  logic [NPIN-1:0] pin_chg_i,
    input  logic [NPIN-1:0] sd_pin_en_i,
    input  logic [2:0]      cause_clr_i,
    output logic [2:0]      state_o,
    output logic            cpu_clk_en_o,
    output logic            mem_clk_en_o,
    output logic            per_clk_en_o,
    output logic            ret_en_o,
    output logic            io_latch_o,
    output logic            bod_en_o,
    output logic            state_clr_o,
    output logic [2:0]      rst_cause_o
);
    localparam int LAT_A   = (LAT_IDLE > LAT_STBY) ? LAT_IDLE : LAT_STBY;
    localparam int LAT_MAX = (LAT_A > LAT_SD) ? LAT_A : LAT_SD;
    localparam int TW      = $clog2(LAT_MAX + 1);

    pms_state_e        state_q, state_n;
    logic              clr_q, clr_set;
    logic [NCAUSE-1:0] cause_q, cause_set;
    logic              tmr_load, tmr_expire;
    logic [TW-1:0]     tmr_val;
    logic              resume, sd_wake;
    logic              bod_pulse, bod_cont;

    pms_wake_filter #(
        .NPIN(NPIN), .IDLE_MASK(IDLE_MASK), .STBY_MASK(STBY_MASK)
    ) u_filter (
        .state_i(state_q), .irq_i(irq_i), .rtc_i(rtc_evt_i), .cop_i(cop_evt_i),
        .pin_chg_i(pin_chg_i), .sd_pin_en_i(sd_pin_en_i),
        .resume_o(resume), .sd_wake_o(sd_wake)
    );

    pms_wake_timer #(.MAXV(LAT_MAX)) u_timer (
        .clk(clk), .por_i(por_i), .load_i(tmr_load),
        .load_val_i(tmr_val), .expire_o(tmr_expire)
    );

    pms_bod_pulser #(.PERIOD(BOD_PERIOD), .ON_CYC(BOD_ON)) u_bod (
        .clk(clk), .por_i(por_i), .en_i(state_q == ST_STANDBY), .pulse_o(bod_pulse)
    );

    // Next-state and side effects
    always_comb begin
        state_n   = state_q;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        clr_set   = 1'b0;
        cause_set = '0;
        if (rstpin_i) begin
            state_n              = ST_WAKE;
            tmr_load             = 1'b1;
            tmr_val              = TW'(LAT_SD);
            clr_set              = 1'b1;
            cause_set[CAUSE_PIN] = 1'b1;
        end else begin
            unique case (state_q)
                ST_ACTIVE: begin
                    if (req_valid_i) begin
                        unique case (req_mode_i)
                            3'd1:    state_n = ST_IDLE;
                            3'd2:    state_n = ST_STANDBY;
                            3'd3:    state_n = ST_SHUTDOWN;
                            default: state_n = ST_ACTIVE;
                        endcase
                    end
                end
                ST_IDLE: begin
                    if (resume) begin
                        state_n  = ST_WAKE;
                        tmr_load = 1'b1;
                        tmr_val  = TW'(LAT_IDLE);
                    end
                end
                ST_STANDBY: begin
                    if (resume) begin
                        state_n  = ST_WAKE;
                        tmr_load = 1'b1;
                        tmr_val  = TW'(LAT_STBY);
                    end
                end
                ST_SHUTDOWN: begin
                    if (sd_wake) begin
                        state_n              = ST_WAKE;
                        tmr_load             = 1'b1;
                        tmr_val              = TW'(LAT_SD);
                        clr_set              = 1'b1;
                        cause_set[CAUSE_SDW] = 1'b1;
                    end
                end
                ST_WAKE: begin
                    if (tmr_expire) state_n = ST_ACTIVE;
                end
                default: state_n = ST_ACTIVE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or posedge por_i) begin
        if (por_i) begin
            state_q <= ST_ACTIVE;
            clr_q   <= 1'b0;
            cause_q <= NCAUSE'(1) << CAUSE_POR;
        end else begin
            state_q <= state_n;
            clr_q   <= clr_set;
            cause_q <= (cause_q & ~cause_clr_i) | cause_set;
        end
    end

    // Outputs
    always_comb begin
        cpu_clk_en_o = 1'b0;
        mem_clk_en_o = 1'b0;
        per_clk_en_o = 1'b0;
        ret_en_o     = 1'b0;
        io_latch_o   = 1'b0;
        bod_cont     = 1'b0;
        unique case (state_q)
            ST_ACTIVE: begin
                cpu_clk_en_o = 1'b1;
                mem_clk_en_o = 1'b1;
                per_clk_en_o = 1'b1;
                bod_cont     = 1'b1;
            end
            ST_IDLE: begin
                per_clk_en_o = 1'b1;
                bod_cont     = 1'b1;
            end
            ST_STANDBY: begin
                ret_en_o   = 1'b1;
                io_latch_o = 1'b1;
            end
            ST_SHUTDOWN: io_latch_o = 1'b1;
            ST_WAKE:     bod_cont   = 1'b1;
            default:     bod_cont   = 1'b1;
        endcase
    end

    assign bod_en_o    = bod_cont | bod_pulse;
    assign state_o     = state_q;
    assign state_clr_o = clr_q;
    assign rst_cause_o = cause_q;

    assert_req_idle_R1: assert property (@(posedge clk) disable iff (por_i)
        (state_q == ST_ACTIVE && req_valid_i && req_mode_i == 3'd1 && !rstpin_i)
        |=> (state_o == 3'd1));
    assert_req_bad_code_R1: assert property (@(posedge clk) disable iff (por_i)
        (state_q == ST_ACTIVE && req_valid_i && req_mode_i[2] && !rstpin_i)
        |=> (state_o == 3'd0));
    assert_wake_no_req_R1: assert property (@(posedge clk) disable iff (por_i)
        (state_q == ST_WAKE && !rstpin_i)
        |=> (state_o == 3'd4 || state_o == 3'd0));
    assert_idle_wake_R3: assert property (@(posedge clk) disable iff (por_i)
        (state_q == ST_IDLE && irq_i && !rstpin_i) |=> (state_o == 3'd4));
    assert_stby_rtc_R4: assert property (@(posedge clk) disable iff (por_i)
        (state_q == ST_STANDBY && rtc_evt_i && !rstpin_i) |=> (state_o == 3'd4));
    assert_sd_hold_R5: assert property (@(posedge clk) disable iff (por_i)
        (state_q == ST_SHUTDOWN && !rstpin_i && !(|(pin_chg_i & sd_pin_en_i)))
        |=> (state_o == 3'd3));
    assert_sd_wake_reset_R5: assert property (@(posedge clk) disable iff (por_i)
        (state_q == ST_SHUTDOWN && !rstpin_i && |(pin_chg_i & sd_pin_en_i))
        |=> (rst_cause_o[CAUSE_SDW] && state_clr_o));
    assert_rstpin_R6: assert property (@(posedge clk) disable iff (por_i)
        rstpin_i |=> (state_o == 3'd4 && rst_cause_o[CAUSE_PIN] && state_clr_o));
    assert_por_clear_R11: assert property (@(posedge clk) disable iff (por_i)
        cause_clr_i[CAUSE_POR] |=> !rst_cause_o[CAUSE_POR]);
endmodule

// File: tb/pwr_mode_seq_tb.sv
module pwr_mode_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NPIN = 4;

    typedef struct {
        int          due;
        int          sel;
        logic [31:0] exp;
        string       req;
    } exp_t;

    logic clk = 1'b0;
    logic por = 1'b1, rstpin = 1'b0, req_valid = 1'b0;
    logic [2:0] req_mode = '0, cause_clr = '0;
    logic irq = 1'b0, rtc = 1'b0, cop = 1'b0;
    logic [NPIN-1:0] pin_chg = '0, sd_en = '0;
    logic [2:0] state_o, cause_o;
    logic cpu_en, mem_en, per_en, ret_en, latch_en, bod_en, clr_o;

    int cyc = 0, checks = 0, fails = 0;
    bit done = 1'b0;
    exp_t q[$];

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    pwr_mode_seq dut_i (
        .clk(clk), .por_i(por), .rstpin_i(rstpin), .req_valid_i(req_valid),
        .req_mode_i(req_mode), .irq_i(irq), .rtc_evt_i(rtc), .cop_evt_i(cop),
        .pin_chg_i(pin_chg), .sd_pin_en_i(sd_en), .cause_clr_i(cause_clr),
        .state_o(state_o), .cpu_clk_en_o(cpu_en), .mem_clk_en_o(mem_en),
        .per_clk_en_o(per_en), .ret_en_o(ret_en), .io_latch_o(latch_en),
        .bod_en_o(bod_en), .state_clr_o(clr_o), .rst_cause_o(cause_o)
    );

    // sel: 0 state 1 cpu 2 mem 3 per 4 ret 5 latch 6 bod 7 cause 8 clr
    function automatic logic [31:0] probe(int sel);
        case (sel)
            0: return {29'd0, state_o};
            1: return {31'd0, cpu_en};
            2: return {31'd0, mem_en};
            3: return {31'd0, per_en};
            4: return {31'd0, ret_en};
            5: return {31'd0, latch_en};
            6: return {31'd0, bod_en};
            7: return {29'd0, cause_o};
            default: return {31'd0, clr_o};
        endcase
    endfunction

    task automatic expect_at(int d, int sel, logic [31:0] v, string r);
        exp_t e;
        e.due = cyc + d; e.sel = sel; e.exp = v; e.req = r;
        q.push_back(e);
    endtask

    task automatic step(int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic drain();
        while (q.size() > 0) @(negedge clk);
        step(1);
    endtask

    task automatic request(logic [2:0] code);
        req_valid = 1'b1; req_mode = code;
        step(1);
        req_valid = 1'b0; req_mode = '0;
    endtask

    // Monitor
    always @(negedge clk) begin
        for (int i = q.size() - 1; i >= 0; i--) begin
            if (q[i].due == cyc) begin
                logic [31:0] act;
                act = probe(q[i].sel);
                checks++;
                if (act !== q[i].exp) begin
                    fails++;
                    $display("FAIL %s sel=%0d cyc=%0d actual=%0h expected=%0h",
                             q[i].req, q[i].sel, cyc, act, q[i].exp);
                end
                q.delete(i);
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        step(3);
        por = 1'b0;
        // R7: power-on state
        expect_at(1, 0, 0, "R7"); expect_at(1, 7, 3'b001, "R7");
        expect_at(1, 1, 1, "R2"); expect_at(1, 6, 1, "R10"); expect_at(1, 5, 0, "R8");
        step(2);
        // R11: write one to clear
        cause_clr = 3'b001; expect_at(1, 7, 0, "R11"); step(1); cause_clr = '0;
        // R1: invalid and no-op codes
        expect_at(1, 0, 0, "R1"); request(3'd5);
        expect_at(1, 0, 0, "R1"); request(3'd0);
        drain();
        // R1/R2: enter idle
        expect_at(1, 0, 1, "R1"); expect_at(1, 1, 0, "R2"); expect_at(1, 2, 0, "R2");
        expect_at(1, 3, 1, "R2"); expect_at(1, 6, 1, "R10"); expect_at(1, 4, 0, "R9");
        request(3'd1);
        // R3: rtc ignored in idle; R1: request ignored outside active
        rtc = 1'b1; expect_at(1, 0, 1, "R3"); step(1); rtc = 1'b0;
        expect_at(1, 0, 1, "R1"); request(3'd2);
        // R3: interrupt wake, latency 14
        irq = 1'b1;
        expect_at(1, 0, 4, "R3"); expect_at(14, 0, 4, "R3"); expect_at(14, 1, 0, "R3");
        expect_at(15, 0, 0, "R3"); expect_at(15, 1, 1, "R3");
        step(1); irq = 1'b0;
        // R1: request during wake countdown is ignored
        expect_at(2, 0, 4, "R1"); request(3'd2);
        drain();
        // R4/R8/R9/R10: standby
        expect_at(1, 0, 2, "R4"); expect_at(1, 4, 1, "R9"); expect_at(1, 5, 1, "R8");
        expect_at(1, 1, 0, "R2"); expect_at(1, 3, 0, "R2");
        expect_at(1, 6, 1, "R10"); expect_at(2, 6, 1, "R10"); expect_at(3, 6, 0, "R10");
        expect_at(17, 6, 1, "R10"); expect_at(18, 6, 1, "R10"); expect_at(19, 6, 0, "R10");
        request(3'd2);
        step(20);
        irq = 1'b1; expect_at(1, 0, 2, "R4"); step(1); irq = 1'b0;
        rtc = 1'b1;
        expect_at(1, 0, 4, "R4"); expect_at(174, 0, 4, "R4");
        expect_at(175, 0, 0, "R4"); expect_at(175, 1, 1, "R4");
        expect_at(175, 4, 0, "R9"); expect_at(175, 5, 0, "R8");
        step(1); rtc = 1'b0;
        drain();
        request(3'd2);
        cop = 1'b1; expect_at(1, 0, 4, "R4"); step(1); cop = 1'b0;
        drain(); step(180);
        request(3'd2);
        pin_chg = 4'b0100; expect_at(1, 0, 4, "R4"); step(1); pin_chg = '0;
        drain(); step(180);
        // R5: shutdown
        expect_at(1, 0, 3, "R5"); expect_at(1, 5, 1, "R8");
        expect_at(1, 6, 0, "R10"); expect_at(1, 4, 0, "R9");
        request(3'd3);
        irq = 1'b1; rtc = 1'b1; cop = 1'b1; pin_chg = 4'b0100; sd_en = 4'b0010;
        expect_at(1, 0, 3, "R5"); expect_at(1, 7, 0, "R5");
        step(1);
        irq = 1'b0; rtc = 1'b0; cop = 1'b0; pin_chg = '0; sd_en = 4'b0100;
        step(1);
        pin_chg = 4'b0100;
        expect_at(1, 0, 4, "R5"); expect_at(1, 8, 1, "R5"); expect_at(1, 7, 3'b100, "R5");
        expect_at(2, 8, 0, "R5"); expect_at(1015, 0, 4, "R5");
        expect_at(1016, 0, 0, "R5"); expect_at(1016, 1, 1, "R5");
        step(1); pin_chg = '0; sd_en = '0;
        drain();
        cause_clr = 3'b111; expect_at(1, 7, 0, "R11"); step(1); cause_clr = '0;
        // R6: reset pin from idle
        request(3'd1);
        rstpin = 1'b1;
        expect_at(1, 0, 4, "R6"); expect_at(1, 7, 3'b010, "R6"); expect_at(1, 8, 1, "R6");
        expect_at(1015, 0, 4, "R6"); expect_at(1016, 0, 0, "R6");
        step(1); rstpin = 1'b0;
        drain();
        cause_clr = 3'b111; step(1); cause_clr = '0;
        // R6 from shutdown, with R11 set-over-clear
        request(3'd3);
        rstpin = 1'b1; cause_clr = 3'b010;
        expect_at(1, 0, 4, "R6"); expect_at(1, 7, 3'b010, "R11"); expect_at(1, 5, 0, "R8");
        step(1); rstpin = 1'b0; cause_clr = '0;
        drain();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule